// File: doc/BRIEF.md
# Line Switch State Decoder with Hold Register

This block is the digital control core of a subscriber line access switch. Three active-high commands (ring, test-in, test-out) pass through a hold register, then through a fixed eight-entry decoder. The decoder drives five switch-group enables: break, ring, ring-test, test-in and test-out. The enables leave the block through a register stage, so they change together on a clock edge and do not glitch while the commands move.

A hold-enable input picks one of two behaviours. While it is low, the register follows the commands. While it is high, the register keeps the commands it last captured. A two-bit shutdown mode input bypasses the hold register completely. It can force every switch off, or it can choose whether a thermal-fault flag is allowed to turn all switches off. When a fault clears, the decoded state comes back without a new command.

Top module: `line_switch_ctrl`

## Requirements
- R1: While rst_n is low all five enables are low and the held commands clear to all-low. With no override, the first clock edge after reset release gives break alone.
- R2: With hold_en low, commands (ring, tin, tout) = 000 give break only. 001 gives test-out only, 010 gives test-in only and 100 gives ring only.
- R3: Command 110 gives ring-test only. Command 011 gives test-in and test-out. Command 111 gives ring-test and test-out.
- R4: Command 101 (ring and test-out with test-in low) turns all five enables off.
- R5: While hold_en is low, a command change reaches the enables on the second rising edge after it is applied: one edge to capture it, one edge to register it.
- R6: While hold_en is high, the enables reflect the commands captured at the last edge where hold_en was sampled low. Later command changes are ignored.
- R7: sd_mode values 2'b10 and 2'b11 turn all enables off on the next edge, whatever the commands or hold_en. The held commands are not altered, so the earlier state returns one edge after the mode goes back to 2'b00.
- R8: In sd_mode 2'b00 (protection active), a high therm_fault turns all enables off on the next edge. One edge after the fault clears, the decoded held state returns.
- R9: In sd_mode 2'b01 (protection disabled), therm_fault has no effect on the enables.
- R10: The break enable is never high in the same cycle as any other enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_ring | input | 1 | Ring command |
| cmd_tin | input | 1 | Test-in command |
| cmd_tout | input | 1 | Test-out command |
| hold_en | input | 1 | 0: hold register follows the commands; 1: it keeps its value |
| sd_mode | input | 2 | 00 protect, 01 no protection, 1x force all off |
| therm_fault | input | 1 | Thermal fault flag |
| sw_break | output | 1 | Break switch group enable |
| sw_ring | output | 1 | Ring switch group enable |
| sw_rtest | output | 1 | Ring-test switch group enable |
| sw_tin | output | 1 | Test-in switch group enable |
| sw_tout | output | 1 | Test-out switch group enable |

## Verification
Two events can land on the same edge: the hold register deciding whether to capture, and the shutdown override. The bench provokes this by raising hold_en, forcing off and presenting a new command all at one clock edge. It then expects all-off, followed by the old state once the force is released, and the new state only after hold_en drops. The bench also clears a thermal fault in the same cycle that a new command arrives. It then judges that the first edge shows the previously held state and the second edge shows the new one.

// File: rtl/lsw_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, command and switch vector types, shutdown modes.
// Assumes commands and enables are active high.
package lsw_pkg;
    localparam int CMD_W = 3;
    localparam int SW_W  = 5;
    localparam int SD_W  = 2;

    typedef struct packed {
        logic ring;
        logic tin;
        logic tout;
    } cmd_t;

    typedef struct packed {
        logic brk;
        logic ring;
        logic rtest;
        logic tin;
        logic tout;
    } sw_t;

    typedef enum logic [SD_W-1:0] {
        SD_PROTECT = 2'b00,
        SD_NOPROT  = 2'b01,
        SD_OFF_A   = 2'b10,
        SD_OFF_B   = 2'b11
    } sd_mode_e;

    localparam sw_t SW_OFF = '0;
endpackage

// File: rtl/lsw_cmd_hold.sv
`timescale 1ns/1ps
// Hold register for the command vector.
// Captures d on every edge where hold_en is sampled low and keeps q while hold_en is high.
// Assumes a synchronous active-low reset that clears the held value to all-low.
module lsw_cmd_hold #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture when transparent, keep when holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!hold_en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lsw_decode.sv
`timescale 1ns/1ps
// Fixed command-to-switch map, purely combinational.
// The map never turns break on together with another group; combination 101 turns everything off.
module lsw_decode
    import lsw_pkg::*;
(
    input  cmd_t cmd,
    output sw_t  sw
);
    // Translate the held command triple into switch-group enables.
    always_comb begin
        sw = SW_OFF;
        unique case ({cmd.ring, cmd.tin, cmd.tout})
            3'b000: sw.brk  = 1'b1;
            3'b001: sw.tout = 1'b1;
            3'b010: sw.tin  = 1'b1;
            3'b100: sw.ring = 1'b1;
            3'b110: sw.rtest = 1'b1;
            3'b011: begin
                sw.tin  = 1'b1;
                sw.tout = 1'b1;
            end
            3'b111: begin
                sw.rtest = 1'b1;
                sw.tout  = 1'b1;
            end
            3'b101: sw = SW_OFF;
            default: sw = SW_OFF;
        endcase
    end
endmodule

// File: rtl/lsw_out_stage.sv
`timescale 1ns/1ps
// Output stage: applies the shutdown/thermal override, then registers each enable.
// The override bypasses the hold register, so it takes effect one edge after it is applied.
// Assumes therm_fault is already synchronous to clk.
module lsw_out_stage
    import lsw_pkg::*;
#(
    parameter int N = SW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  dec,
    input  logic [SD_W-1:0] sd_mode,
    input  logic          therm_fault,
    output logic [N-1:0]  q
);
    logic         force_off;
    logic [N-1:0] nxt;

    // Work out whether any override forces all groups off.
    always_comb begin
        force_off = sd_mode[1] || ((sd_mode == SD_PROTECT) && therm_fault);
        nxt       = force_off ? '0 : dec;
    end

    // One flop for each enable, all updating on the same edge.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/line_switch_ctrl.sv
`timescale 1ns/1ps
// Top: line switch state control. Commands -> hold register -> decoder -> override + output flops.
// Command latency is two edges; override latency is one edge.
module line_switch_ctrl
    import lsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_ring,
    input  logic       cmd_tin,
    input  logic       cmd_tout,
    input  logic       hold_en,
    input  logic [1:0] sd_mode,
    input  logic       therm_fault,
    output logic       sw_break,
    output logic       sw_ring,
    output logic       sw_rtest,
    output logic       sw_tin,
    output logic       sw_tout
);
    cmd_t            cmd_in;
    logic [CMD_W-1:0] held_bits;
    cmd_t            held;
    sw_t             dec;
    logic [SW_W-1:0] sw_q;
    sw_t             sw_s;

    // Pack the command pins into one vector.
    always_comb begin
        cmd_in.ring = cmd_ring;
        cmd_in.tin  = cmd_tin;
        cmd_in.tout = cmd_tout;
        held        = cmd_t'(held_bits);
        sw_s        = sw_t'(sw_q);
    end

    lsw_cmd_hold #(.W(CMD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_en (hold_en),
        .d       (cmd_in),
        .q       (held_bits)
    );

    lsw_decode u_dec (
        .cmd (held),
        .sw  (dec)
    );

    lsw_out_stage #(.N(SW_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .sd_mode     (sd_mode),
        .therm_fault (therm_fault),
        .q           (sw_q)
    );

    // Unpack the registered enables to the pins.
    always_comb begin
        sw_break = sw_s.brk;
        sw_ring  = sw_s.ring;
        sw_rtest = sw_s.rtest;
        sw_tin   = sw_s.tin;
        sw_tout  = sw_s.tout;
    end
endmodule

// File: rtl/lsw_checker.sv
`timescale 1ns/1ps
// Checker for line_switch_ctrl, attached by bind. Observes ports only.
module lsw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_en,
    input logic [1:0] sd_mode,
    input logic       therm_fault,
    input logic       sw_break,
    input logic       sw_ring,
    input logic       sw_rtest,
    input logic       sw_tin,
    input logic       sw_tout
);
    logic [4:0] sw_all;
    logic       ovr;
    logic [1:0] age;
    logic       hold_q1, hold_q2, ovr_q1, ovr_q2;

    // Combine the enables and the override condition.
    always_comb begin
        sw_all = {sw_break, sw_ring, sw_rtest, sw_tin, sw_tout};
        ovr    = sd_mode[1] || ((sd_mode == 2'b00) && therm_fault);
    end

    // History of hold and override over two edges, plus cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0; hold_q1 <= 1'b0; hold_q2 <= 1'b0; ovr_q1 <= 1'b1; ovr_q2 <= 1'b1;
        end else begin
            if (age != 2'd3) age <= age + 2'd1;
            hold_q1 <= hold_en; hold_q2 <= hold_q1;
            ovr_q1  <= ovr;     ovr_q2  <= ovr_q1;
        end
    end

    AST_BREAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        sw_break |-> (sw_all[3:0] == 4'b0000)); // R10
    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sd_mode[1] |=> (sw_all == 5'b00000)); // R7
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_mode == 2'b00) && therm_fault) |=> (sw_all == 5'b00000)); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && hold_q2 && !ovr_q1 && !ovr_q2) |-> $stable(sw_all)); // R6
endmodule

bind line_switch_ctrl lsw_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_en     (hold_en),
    .sd_mode     (sd_mode),
    .therm_fault (therm_fault),
    .sw_break    (sw_break),
    .sw_ring     (sw_ring),
    .sw_rtest    (sw_rtest),
    .sw_tin      (sw_tin),
    .sw_tout     (sw_tout)
);

// File: tb/sim_line_switch_ctrl.sv
`timescale 1ns/1ps
module sim_line_switch_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_ring = 1'b0, cmd_tin = 1'b0, cmd_tout = 1'b0;
    logic hold_en = 1'b0;
    logic [1:0] sd_mode = 2'b00;
    logic therm_fault = 1'b0;
    logic sw_break, sw_ring, sw_rtest, sw_tin, sw_tout;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_switch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_ring(cmd_ring), .cmd_tin(cmd_tin), .cmd_tout(cmd_tout),
        .hold_en(hold_en), .sd_mode(sd_mode), .therm_fault(therm_fault),
        .sw_break(sw_break), .sw_ring(sw_ring), .sw_rtest(sw_rtest), .sw_tin(sw_tin), .sw_tout(sw_tout)
    );

    // Expected enables {break, ring, rtest, tin, tout} for commands {ring, tin, tout}.
    function automatic logic [4:0] want(input logic [2:0] c);
        case (c)
            3'b000: return 5'b10000;
            3'b001: return 5'b00001;
            3'b010: return 5'b00010;
            3'b100: return 5'b01000;
            3'b110: return 5'b00100;
            3'b011: return 5'b00011;
            3'b111: return 5'b00101;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {sw_break, sw_ring, sw_rtest, sw_tin, sw_tout};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input logic [2:0] c);
        @(negedge clk);
        {cmd_ring, cmd_tin, cmd_tout} = c;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        {cmd_ring, cmd_tin, cmd_tout} = 3'b110;
        edges(3);
        check("R1 in reset", 5'b00000);
        @(negedge clk); rst_n = 1'b1; {cmd_ring, cmd_tin, cmd_tout} = 3'b000;
        edges(1);
        check("R1 first edge after reset", 5'b10000);
    endtask

    task automatic t_map();
        for (int i = 0; i < 8; i++) begin
            drive(i[2:0]);
            edges(2);
            if (i == 5) check("R4 ring+tout all off", want(3'(i)));
            else if (i == 3 || i == 6 || i == 7) check("R3 merged map", want(3'(i)));
            else check("R2 single map", want(3'(i)));
            checks++;
            if (sw_break && (sw_ring | sw_rtest | sw_tin | sw_tout)) begin
                errors++;
                $display("FAIL R10 break with other group got=%b exp=exclusive",
                         {sw_break, sw_ring, sw_rtest, sw_tin, sw_tout});
            end
        end
    endtask

    task automatic t_transparent();
        drive(3'b000); edges(2);
        drive(3'b010);
        edges(1);
        check("R5 not yet after one edge", 5'b10000);
        edges(1);
        check("R5 arrives on second edge", 5'b00010);
    endtask

    task automatic t_hold();
        drive(3'b100); edges(2);
        @(negedge clk); hold_en = 1'b1; {cmd_ring, cmd_tin, cmd_tout} = 3'b011;
        edges(3);
        check("R6 frozen after change", 5'b01000);
        drive(3'b000); edges(2);
        check("R6 still frozen", 5'b01000);
        @(negedge clk); hold_en = 1'b0;
        edges(2);
        check("R6 release captures", 5'b10000);
    endtask

    task automatic t_force();
        drive(3'b001); edges(2);
        @(negedge clk); sd_mode = 2'b10;
        edges(1);
        check("R7 force off 10", 5'b00000);
        @(negedge clk); sd_mode = 2'b11; {cmd_ring, cmd_tin, cmd_tout} = 3'b000;
        edges(2);
        check("R7 force off 11", 5'b00000);
        @(negedge clk); sd_mode = 2'b00;
        edges(1);
        check("R7 release shows held", 5'b10000);
    endtask

    task automatic t_thermal();
        drive(3'b010); edges(2);
        @(negedge clk); therm_fault = 1'b1;
        edges(1);
        check("R8 fault forces off", 5'b00000);
        @(negedge clk); therm_fault = 1'b0;
        edges(1);
        check("R8 fault clear restores", 5'b00010);
        @(negedge clk); sd_mode = 2'b01; therm_fault = 1'b1;
        edges(2);
        check("R9 fault ignored when disabled", 5'b00010);
        @(negedge clk); sd_mode = 2'b00; therm_fault = 1'b0;
        edges(1);
    endtask

    task automatic t_collide();
        drive(3'b001); edges(2);
        @(negedge clk); hold_en = 1'b1; sd_mode = 2'b10; {cmd_ring, cmd_tin, cmd_tout} = 3'b100;
        edges(2);
        check("R7 force during hold", 5'b00000);
        @(negedge clk); sd_mode = 2'b00;
        edges(1);
        check("R6 old state kept across force", 5'b00001);
        @(negedge clk); hold_en = 1'b0;
        edges(2);
        check("R5 new command after release", 5'b01000);
        @(negedge clk); therm_fault = 1'b1; {cmd_ring, cmd_tin, cmd_tout} = 3'b110;
        edges(2);
        @(negedge clk); therm_fault = 1'b0; {cmd_ring, cmd_tin, cmd_tout} = 3'b011;
        edges(1);
        check("R8 clear shows prior held", 5'b00100);
        edges(1);
        check("R5 new command next edge", 5'b00011);
    endtask

    initial begin
        t_reset();
        t_map();
        t_transparent();
        t_hold();
        t_force();
        t_thermal();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule